// File: doc/BRIEF.md
# Replacement Victim Selector

This block chooses which way of a set-associative cache set gets evicted when a lookup has missed on every way. For each way it receives a two-bit coherence state, an age (a larger age means the line was used less recently) and a flag that marks the way as having an outstanding miss or upgrade. Ways with such an outstanding entry are never evicted. Among the remaining ways the block prefers the cheapest line to give up. An invalid line comes first, then a shared clean line, then a private clean line, and a private dirty line only as a last resort. Within that class it takes the oldest line.

The choice is made combinationally in the cycle when `start` is high. On the next clock edge the block registers the result and pulses either `res_valid` or `res_fail` for one cycle. With `res_valid`, `res_way` names the victim and `age_out` holds the rewritten ages of the set, with the victim now the most recently used line. With `res_fail`, every way was blocked and `age_out` holds the input ages unchanged.

All pins are plain control and status pins. A request is accepted on every cycle when `start` is high, so back-to-back requests give back-to-back result pulses. Nothing applies back-pressure: the result is present for one cycle only, and the requester must take it in that cycle.

Top module: `repl_victim_sel`

## Requirements
- R1: A way whose bit in `busy_in` is 1 is never reported as the victim.
- R2: Non-busy ways are ranked by state class, using the encoding 2'b00 invalid, 2'b01 shared clean, 2'b10 private clean, 2'b11 private dirty. The victim comes from the lowest-encoded class that has at least one non-busy way.
- R3: Within the chosen class, the way with the largest age is the victim. When ages are equal, the lowest-numbered way wins.
- R4: If every way is busy, the block pulses `res_fail` and sets `age_out` equal to the `age_in` presented with `start`.
- R5: On success, the victim's age in `age_out` is 1. Every other way whose input age is strictly below the victim's input age comes out incremented by one. All remaining ways keep their input age.
- R6: A result pulse appears exactly one cycle after `start`. `res_valid` and `res_fail` are never high together, and neither is high in a cycle that does not follow a `start`.
- R7: During reset, `res_valid`, `res_fail`, `res_way` and `age_out` are all zero.
- R8: While `start` is low, `age_out` and `res_way` hold their values, whatever the other inputs do.
- Fields are packed with way 0 in the least significant bits: way i uses `state_in[2i+1:2i]` and `age_in`/`age_out` bits `[4i+3:4i]` with the default age width of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a victim choice for the set presented this cycle |
| state_in | input | 2*WAYS | Coherence state per way |
| age_in | input | AGE_W*WAYS | Age per way, larger is older |
| busy_in | input | WAYS | Way has an outstanding miss or upgrade |
| res_valid | output | 1 | One-cycle pulse: a victim was chosen |
| res_fail | output | 1 | One-cycle pulse: every way was busy |
| res_way | output | $clog2(WAYS) | Victim way index |
| age_out | output | AGE_W*WAYS | Rewritten ages of the set |

## Verification
On every cycle, the in-RTL assertions check that a chosen way is never busy and that an all-busy set always fails. They also check that a result pulse follows only a start, that success and failure never coincide, that the victim's age lands at 1, and that a failure leaves the ages untouched. The ranking, which needs a comparison across classes and ages, and the exact aging of the other ways can only be shown by the bench scenarios. Those scenarios compare each result with an independent model over directed and random state, age and busy patterns, including ties and the hold behaviour while `start` is low.

// File: rtl/repl_sel_pkg.sv
package repl_sel_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHC = 2'b01,
    ST_PRC = 2'b10,
    ST_PRD = 2'b11
  } line_st_e;

  localparam int NUM_CLASSES = 4;
  localparam int ST_W        = 2;
endpackage

// File: rtl/repl_sel_oldest.sv
// Finds the oldest eligible way; strict comparison keeps the lowest index on ties.
module repl_sel_oldest #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       elig,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic                  found,
  output logic [IDX_W-1:0]      way,
  output logic [AGE_W-1:0]      age
);
  always_comb begin
    found = 1'b0;
    way   = '0;
    age   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (elig[i] && (!found || ages[i*AGE_W +: AGE_W] > age)) begin
        found = 1'b1;
        way   = IDX_W'(i);
        age   = ages[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/repl_sel_prio.sv
// Takes the first class (lowest encoding) that has a candidate.
module repl_sel_prio #(
  parameter int WAYS    = 8,
  parameter int AGE_W   = 4,
  parameter int CLASSES = 4,
  localparam int IDX_W  = $clog2(WAYS)
) (
  input  logic [CLASSES-1:0]       cls_found,
  input  logic [CLASSES*IDX_W-1:0] cls_way,
  input  logic [CLASSES*AGE_W-1:0] cls_age,
  output logic                     pick_ok,
  output logic [IDX_W-1:0]         pick_way,
  output logic [AGE_W-1:0]         pick_age
);
  always_comb begin
    pick_ok  = 1'b0;
    pick_way = '0;
    pick_age = '0;
    for (int c = 0; c < CLASSES; c++) begin
      if (!pick_ok && cls_found[c]) begin
        pick_ok  = 1'b1;
        pick_way = cls_way[c*IDX_W +: IDX_W];
        pick_age = cls_age[c*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/repl_sel_age.sv
// Rewrites the ages so the victim becomes most recently used.
module repl_sel_age #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS*AGE_W-1:0] ages,
  input  logic [IDX_W-1:0]      victim,
  input  logic [AGE_W-1:0]      vic_age,
  output logic [WAYS*AGE_W-1:0] ages_new
);
  for (genvar i = 0; i < WAYS; i++) begin : g_way
    logic [AGE_W-1:0] cur;
    assign cur = ages[i*AGE_W +: AGE_W];
    always_comb begin
      if (victim == IDX_W'(i))
        ages_new[i*AGE_W +: AGE_W] = AGE_W'(1);
      else if (cur < vic_age)
        ages_new[i*AGE_W +: AGE_W] = cur + AGE_W'(1);
      else
        ages_new[i*AGE_W +: AGE_W] = cur;
    end
  end
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2*WAYS-1:0]     state_in,
  input  logic [WAYS*AGE_W-1:0] age_in,
  input  logic [WAYS-1:0]       busy_in,
  output logic                  res_valid,
  output logic                  res_fail,
  output logic [IDX_W-1:0]      res_way,
  output logic [WAYS*AGE_W-1:0] age_out
);
  import repl_sel_pkg::*;

  logic [NUM_CLASSES-1:0][WAYS-1:0] elig;
  logic [NUM_CLASSES-1:0]           cls_found;
  logic [NUM_CLASSES*IDX_W-1:0]     cls_way;
  logic [NUM_CLASSES*AGE_W-1:0]     cls_age;
  logic                             sel_ok;
  logic [IDX_W-1:0]                 sel_way;
  logic [AGE_W-1:0]                 sel_age;
  logic [WAYS*AGE_W-1:0]            ages_new;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    for (genvar i = 0; i < WAYS; i++) begin : g_elig
      assign elig[c][i] = !busy_in[i] && (state_in[i*ST_W +: ST_W] == ST_W'(c));
    end
    repl_sel_oldest #(.WAYS(WAYS), .AGE_W(AGE_W)) u_oldest (
      .elig  (elig[c]),
      .ages  (age_in),
      .found (cls_found[c]),
      .way   (cls_way[c*IDX_W +: IDX_W]),
      .age   (cls_age[c*AGE_W +: AGE_W])
    );
  end

  repl_sel_prio #(.WAYS(WAYS), .AGE_W(AGE_W), .CLASSES(NUM_CLASSES)) u_prio (
    .cls_found (cls_found),
    .cls_way   (cls_way),
    .cls_age   (cls_age),
    .pick_ok   (sel_ok),
    .pick_way  (sel_way),
    .pick_age  (sel_age)
  );

  repl_sel_age #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .ages     (age_in),
    .victim   (sel_way),
    .vic_age  (sel_age),
    .ages_new (ages_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
      res_way   <= '0;
      age_out   <= '0;
    end else if (start) begin
      res_valid <= sel_ok;
      res_fail  <= !sel_ok;
      res_way   <= sel_ok ? sel_way : '0;
      age_out   <= sel_ok ? ages_new : age_in;
    end else begin
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
    end
  end

  assert_busy_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel_ok) |-> !busy_in[sel_way]);

  assert_all_busy_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (&busy_in)) |-> !sel_ok);

  assert_fail_keeps_ages_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_fail |-> (age_out == $past(age_in)));

  assert_victim_age_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (age_out[res_way*AGE_W +: AGE_W] == AGE_W'(1)));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_fail));

  assert_pulse_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || res_fail) |-> $past(start));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start) && $past(rst_n)) |-> ($stable(age_out) && $stable(res_way)));
endmodule

// File: tb/repl_victim_sel_test.sv
module repl_victim_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 8;
  localparam int AGE_W = 4;
  localparam int IDX_W = $clog2(WAYS);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [2*WAYS-1:0]     state_in = '0;
  logic [WAYS*AGE_W-1:0] age_in = '0;
  logic [WAYS-1:0]       busy_in = '0;
  logic                  res_valid, res_fail;
  logic [IDX_W-1:0]      res_way;
  logic [WAYS*AGE_W-1:0] age_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .age_in(age_in), .busy_in(busy_in), .res_valid(res_valid),
    .res_fail(res_fail), .res_way(res_way), .age_out(age_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent model: scan classes in rank order, oldest with strict compare.
  task automatic model(input logic [2*WAYS-1:0] st, input logic [WAYS*AGE_W-1:0] ag,
                       input logic [WAYS-1:0] bz, output bit ok, output int way,
                       output logic [WAYS*AGE_W-1:0] nag);
    int best_age;
    ok = 0; way = 0; best_age = -1; nag = ag;
    for (int c = 0; c < 4 && !ok; c++) begin
      for (int i = 0; i < WAYS; i++) begin
        if (!bz[i] && int'(st[2*i +: 2]) == c && int'(ag[i*AGE_W +: AGE_W]) > best_age) begin
          best_age = int'(ag[i*AGE_W +: AGE_W]);
          way = i;
          ok = 1;
        end
      end
    end
    if (ok) begin
      for (int i = 0; i < WAYS; i++) begin
        if (i == way) nag[i*AGE_W +: AGE_W] = AGE_W'(1);
        else if (int'(ag[i*AGE_W +: AGE_W]) < best_age)
          nag[i*AGE_W +: AGE_W] = ag[i*AGE_W +: AGE_W] + AGE_W'(1);
      end
    end
  endtask

  // Called at a negedge; returns the observed way after checking against the model.
  task automatic run_case(input string req, input logic [2*WAYS-1:0] st,
                          input logic [WAYS*AGE_W-1:0] ag, input logic [WAYS-1:0] bz,
                          output int got_way);
    bit ok; int way; logic [WAYS*AGE_W-1:0] nag;
    model(st, ag, bz, ok, way, nag);
    state_in = st; age_in = ag; busy_in = bz; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    got_way = int'(res_way);
    chk(res_valid == ok && res_fail == !ok, "R6", "valid/fail", {res_valid, res_fail}, {ok, !ok});
    if (ok) begin
      chk(!bz[res_way], "R1", "victim not busy", 64'(bz), 64'(res_way));
      chk(int'(res_way) == way, req, "victim way", 64'(res_way), 64'(way));
      chk(age_out == nag, "R5", "ages", 64'(age_out), 64'(nag));
    end else begin
      chk(age_out == ag, "R4", "ages on fail", 64'(age_out), 64'(ag));
    end
    @(posedge clk); @(negedge clk);
    chk(!res_valid && !res_fail, "R6", "single-cycle pulse", {res_valid, res_fail}, 64'd0);
  endtask

  task automatic t_reset();
    chk(!res_valid && !res_fail && res_way == '0 && age_out == '0, "R7", "reset state",
        {res_valid, res_fail, 4'(res_way), age_out}, 64'd0);
  endtask

  task automatic t_priority();
    int w;
    run_case("R2", 16'hF3FF, 32'h99099999, 8'h00, w);
    chk(w == 5, "R2", "invalid beats older dirty", 64'(w), 64'd5);
    run_case("R2", 16'hDFDB, 32'hF8FFF4FF, 8'h00, w);
    chk(w == 6, "R2", "oldest shared clean chosen", 64'(w), 64'd6);
    run_case("R2", 16'hDFDB, 32'hF8FFF4FF, 8'h44, w);
    chk(w == 1, "R2", "private clean when shared busy", 64'(w), 64'd1);
  endtask

  task automatic t_ties();
    int w;
    run_case("R3", 16'h5555, 32'h77777777, 8'h00, w);
    chk(w == 0, "R3", "tie lowest way", 64'(w), 64'd0);
    run_case("R3", 16'h5555, 32'h77777777, 8'h01, w);
    chk(w == 1, "R1", "busy way0 skipped", 64'(w), 64'd1);
  endtask

  task automatic t_aging();
    int w;
    run_case("R5", 16'hFF3F, 32'h26043512, 8'h00, w);
    chk(w == 3, "R5", "invalid way picked", 64'(w), 64'd3);
    chk(age_out == 32'h36141523, "R5", "aged vector", 64'(age_out), 64'h36141523);
  endtask

  task automatic t_all_busy();
    int w;
    run_case("R4", 16'h1B1B, 32'h12345678, 8'hFF, w);
    chk(age_out == 32'h12345678, "R4", "ages unchanged", 64'(age_out), 64'h12345678);
  endtask

  task automatic t_hold();
    logic [WAYS*AGE_W-1:0] keep;
    logic [IDX_W-1:0] kway;
    int w;
    run_case("R8", 16'h0000, 32'h00000005, 8'h00, w);
    keep = age_out; kway = res_way;
    state_in = 16'hFFFF; age_in = 32'hABCDEF01; busy_in = 8'h0F;
    repeat (3) @(negedge clk);
    chk(age_out == keep && res_way == kway, "R8", "hold without start",
        64'(age_out), 64'(keep));
    chk(!res_valid && !res_fail, "R6", "no pulse without start", {res_valid, res_fail}, 64'd0);
  endtask

  task automatic t_random();
    int w;
    for (int k = 0; k < 300; k++) begin
      run_case("R2", 16'($urandom), $urandom,
               8'($urandom) & 8'($urandom) | ((k % 25 == 0) ? 8'hFF : 8'h00), w);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_priority();
    t_ties();
    t_aging();
    t_all_busy();
    t_hold();
    t_random();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule